// File: doc/BRIEF.md
# Signed Integer Divide Unit with Condition Flags

This block performs signed integer division for a processor execution stage. A divide takes several clock cycles. A single `start` pulse captures a dividend, a divisor, a form select and the incoming extend flag. The block then iterates one quotient bit per clock on the operand magnitudes and corrects the signs at the end. The quotient is truncated toward zero, and the remainder carries the sign of the dividend.

Four forms are supported:

- **Half-width:** a full-width dividend divided by a half-width divisor. The quotient and remainder are packed together into one full-width result.
- **Long:** full width by full width, quotient only.
- **Long with remainder:** full width by full width, quotient and remainder both returned.
- **Double:** a double-width dividend, supplied as a high and a low word, divided by a full-width divisor.

When the divide finishes, the unit raises `done` for one cycle. In that cycle it presents:

- the result words,
- the write enables that tell writeback what to store,
- the condition flags,
- a trap request for a zero divisor.

If the quotient cannot fit its destination, both write enables stay low, so the destination registers keep their old contents. Instruction decode, writeback and exception sequencing are handled by the surrounding pipeline.

Top module: `divs_unit`

## Requirements
- R1: With `form`=0 (half-width), the dividend is `dvd_lo` (DW bits) and the divisor is `dvs[DW/2-1:0]`; the upper divisor bits and `dvd_hi` are ignored. `result_q` holds the quotient in bits [DW/2-1:0] and the remainder in bits [DW-1:DW/2]. `wr_q`=1 and `wr_r`=0.
- R2: With `form`=1 (long), the signed quotient of `dvd_lo`/`dvs` appears on `result_q` with `wr_q`=1 and `wr_r`=0; `dvd_hi` is ignored.
- R3: With `form`=2 (long with remainder), the quotient appears on `result_q` and the remainder on `result_r`, with `wr_q`=1 and `wr_r`=1.
- R4: With `form`=3 (double), the dividend is {`dvd_hi`,`dvd_lo`}. The quotient appears on `result_q` and the remainder on `result_r`, and both write enables are 1.
- R5: A zero divisor (counting only the low half in form 0) gives `trap_zero`=1 and `wr_q`=`wr_r`=0, with `flag_n`, `flag_z` and `flag_v` all 0.
- R6: A quotient outside the signed range of its destination (DW/2 bits in form 0, DW bits otherwise) gives `flag_v`=1, `wr_q`=`wr_r`=0 and `flag_n`=`flag_z`=0. A quotient exactly equal to the most negative value is not an overflow, while the most negative dividend divided by -1 is.
- R7: On a written result, `flag_n` equals the quotient's sign, `flag_z` is 1 exactly when the quotient is zero, and `flag_v` is 0. `flag_c` is always 0, and `flag_x` repeats the `x_in` value captured at start.
- R8: A divide with a zero divisor, or one where |dividend| shifted right by the quotient width is at least |divisor|, completes early. In that case `done` is seen 1 cycle after the start edge. Any other divide shows `done` after Q+1 edges, where Q is DW/2 in form 0 and DW otherwise.
- R9: `done` lasts exactly one cycle. `busy` is high from the accepted start until `done` falls. A `start` that arrives while busy is ignored. `wr_q`, `wr_r`, `trap_zero`, `flag_n`, `flag_z` and `flag_v` are 0 whenever `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a divide (accepted when idle) |
| form | input | 2 | 0 half-width, 1 long, 2 long+remainder, 3 double |
| dvd_hi | input | DW | Upper dividend word (double form only) |
| dvd_lo | input | DW | Lower / whole dividend word |
| dvs | input | DW | Divisor |
| x_in | input | 1 | Incoming extend flag |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle completion strobe |
| result_q | output | DW | Quotient, or packed remainder:quotient in form 0 |
| result_r | output | DW | Remainder (forms 2 and 3) |
| wr_q | output | 1 | Write result_q to destination |
| wr_r | output | 1 | Write result_r to destination |
| flag_x | output | 1 | Extend flag, unchanged |
| flag_n | output | 1 | Quotient negative |
| flag_z | output | 1 | Quotient zero |
| flag_v | output | 1 | Quotient overflow |
| flag_c | output | 1 | Carry, always clear |
| trap_zero | output | 1 | Divide-by-zero trap request |

## Verification
The bench runs with an 8-bit configuration:

- **Half-width form:** swept exhaustively over every dividend and every 4-bit divisor.
- **Long forms:** every dividend (every other one for the remainder form) against a divisor set of zero, ±1, powers of two and the extremes.
- **Double form:** a grid of high and low words, plus directed cases.

The sweep targets three kinds of error:

- **Remainder sign:** a design that floors instead of truncating would return a positive remainder for a negative dividend.
- **Overflow bound:** an off-by-one would either flag a quotient of exactly the most negative value or miss the case of the most negative dividend divided by -1.
- **Early detection:** a faulty check would show up as the wrong completion latency, or as a quotient wrapped into the destination.

Directed cases also confirm that a second start during a divide changes nothing, and that writes, flags and trap stay low outside the done strobe.

// File: rtl/divs_pkg.sv
package divs_pkg;

  typedef enum logic [1:0] {
    FORM_HALF  = 2'd0,
    FORM_LONG  = 2'd1,
    FORM_LONGR = 2'd2,
    FORM_DBL   = 2'd3
  } divs_form_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } divs_state_e;

endpackage

// File: rtl/divs_prep.sv
// Operand selection, magnitude conversion and early overflow / zero detection.
module divs_prep
  import divs_pkg::*;
#(
  parameter int DW = 32
) (
  input  divs_form_e       form,
  input  logic [DW-1:0]    dvd_hi,
  input  logic [DW-1:0]    dvd_lo,
  input  logic [DW-1:0]    dvs,
  output logic             a_neg,
  output logic             q_neg,
  output logic [DW-1:0]    p0,
  output logic [DW-1:0]    s0,
  output logic [DW-1:0]    b_mag,
  output logic             div_zero,
  output logic             early_ovf
);
  localparam int H  = DW / 2;
  localparam int AW = 2 * DW;

  logic [AW-1:0] dsx;
  logic [AW-1:0] a_mag;
  logic [DW-1:0] bsx;

  always_comb begin
    dsx = {{DW{dvd_lo[DW-1]}}, dvd_lo};
    bsx = dvs;
    case (form)
      FORM_HALF: bsx = {{(DW-H){dvs[H-1]}}, dvs[H-1:0]};
      FORM_DBL:  dsx = {dvd_hi, dvd_lo};
      default: ;
    endcase
    a_neg = dsx[AW-1];
    q_neg = dsx[AW-1] ^ bsx[DW-1];
    a_mag = dsx[AW-1] ? -dsx : dsx;
    b_mag = bsx[DW-1] ? -bsx : bsx;
    if (form == FORM_HALF) begin
      // quotient has H bits: partial remainder starts with a_mag >> H
      p0 = a_mag[DW+H-1:H];
      s0 = {a_mag[H-1:0], {(DW-H){1'b0}}};
    end else begin
      p0 = a_mag[AW-1:DW];
      s0 = a_mag[DW-1:0];
    end
    div_zero  = (b_mag == '0);
    early_ovf = (p0 >= b_mag);
  end

endmodule

// File: rtl/divs_core.sv
// Sequencer and restoring shift-subtract datapath, one quotient bit per clock.
module divs_core
  import divs_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  divs_form_e       form_in,
  input  logic             a_neg_in,
  input  logic             q_neg_in,
  input  logic             zero_in,
  input  logic             eovf_in,
  input  logic             x_in,
  input  logic [DW-1:0]    p0,
  input  logic [DW-1:0]    s0,
  input  logic [DW-1:0]    b_in,
  output logic             busy,
  output logic             done,
  output divs_form_e       form_q,
  output logic             a_neg_q,
  output logic             q_neg_q,
  output logic             zero_q,
  output logic             eovf_q,
  output logic             x_q,
  output logic [DW-1:0]    p_q,
  output logic [DW-1:0]    s_q
);
  localparam int H  = DW / 2;
  localparam int CW = $clog2(DW + 1);

  divs_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] b_q;
  logic [DW-1:0] p_d, s_d;
  logic [DW:0]   trial;
  logic          ge;
  logic          ld_en, step_en;

  // next-state and datapath step
  always_comb begin
    trial   = {p_q, s_q[DW-1]};
    ge      = (trial >= {1'b0, b_q});
    st_d    = st_q;
    cnt_d   = cnt_q;
    p_d     = p_q;
    s_d     = s_q;
    ld_en   = 1'b0;
    step_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          ld_en = 1'b1;
          p_d   = p0;
          s_d   = s0;
          cnt_d = (form_in == FORM_HALF) ? CW'(H) : CW'(DW);
          st_d  = (zero_in || eovf_in) ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        step_en = 1'b1;
        p_d     = ge ? DW'(trial - {1'b0, b_q}) : trial[DW-1:0];
        s_d     = {s_q[DW-2:0], ge};
        cnt_d   = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) st_d = ST_FIN;
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (ld_en || step_en) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      form_q  <= form_in;
      a_neg_q <= a_neg_in;
      q_neg_q <= q_neg_in;
      zero_q  <= zero_in;
      eovf_q  <= eovf_in;
      x_q     <= x_in;
      b_q     <= b_in;
    end
    if (ld_en || step_en) begin
      p_q <= p_d;
      s_q <= s_d;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = (st_q == ST_FIN);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |=> ($stable(form_q) && $stable(x_q) && $stable(b_q)));
  assert_short_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start && (zero_in || eovf_in)) |=> done);
  assert_count_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && cnt_q != CW'(1)) |=> (st_q == ST_RUN && cnt_q == $past(cnt_q) - 1'b1));
  assert_rem_below_divisor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> (p_q < b_q));

endmodule

// File: rtl/divs_fix.sv
// Sign correction, late overflow bound, result packing and flag generation.
module divs_fix
  import divs_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             done,
  input  divs_form_e       form,
  input  logic             a_neg,
  input  logic             q_neg,
  input  logic             zero,
  input  logic             eovf,
  input  logic             x,
  input  logic [DW-1:0]    p,
  input  logic [DW-1:0]    s,
  output logic [DW-1:0]    result_q,
  output logic [DW-1:0]    result_r,
  output logic             wr_q,
  output logic             wr_r,
  output logic             flag_x,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c,
  output logic             trap_zero
);
  localparam int H = DW / 2;

  logic          half;
  logic [DW-1:0] qmag, lim, qs, rs;
  logic          ovf, qsign, good;

  always_comb begin
    half  = (form == FORM_HALF);
    qmag  = half ? {{(DW-H){1'b0}}, s[H-1:0]} : s;
    lim   = half ? (DW'(1) << (H - 1)) : (DW'(1) << (DW - 1));
    // magnitude limit: negative quotients reach one further than positive
    ovf   = eovf || (q_neg ? (qmag > lim) : (qmag >= lim));
    qs    = q_neg ? -qmag : qmag;
    rs    = a_neg ? -p : p;
    qsign = half ? qs[H-1] : qs[DW-1];
    good  = done && !zero && !ovf;

    result_q  = half ? {rs[DW-H-1:0], qs[H-1:0]} : qs;
    result_r  = rs;
    wr_q      = good;
    wr_r      = good && (form == FORM_LONGR || form == FORM_DBL);
    flag_n    = good && qsign;
    flag_z    = good && (qmag == '0);
    flag_v    = done && !zero && ovf;
    flag_c    = 1'b0;
    flag_x    = x;
    trap_zero = done && zero;
  end

endmodule

// File: rtl/divs_unit.sv
module divs_unit
  import divs_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    form,
  input  logic [DW-1:0] dvd_hi,
  input  logic [DW-1:0] dvd_lo,
  input  logic [DW-1:0] dvs,
  input  logic          x_in,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result_q,
  output logic [DW-1:0] result_r,
  output logic          wr_q,
  output logic          wr_r,
  output logic          flag_x,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_v,
  output logic          flag_c,
  output logic          trap_zero
);
  logic          rst_m_q, rst_s_q;
  divs_form_e    form_e, form_q;
  logic          a_neg, q_neg, div_zero, early_ovf;
  logic [DW-1:0] p0, s0, b_mag;
  logic          a_neg_q, q_neg_q, zero_q, eovf_q, x_q;
  logic [DW-1:0] p_q, s_q;

  // reset asserts asynchronously, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  assign form_e = divs_form_e'(form);

  divs_prep #(.DW(DW)) u_prep (
    .form(form_e), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvs(dvs),
    .a_neg(a_neg), .q_neg(q_neg), .p0(p0), .s0(s0), .b_mag(b_mag),
    .div_zero(div_zero), .early_ovf(early_ovf)
  );

  divs_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_s_q), .start(start), .form_in(form_e),
    .a_neg_in(a_neg), .q_neg_in(q_neg), .zero_in(div_zero), .eovf_in(early_ovf),
    .x_in(x_in), .p0(p0), .s0(s0), .b_in(b_mag),
    .busy(busy), .done(done), .form_q(form_q), .a_neg_q(a_neg_q), .q_neg_q(q_neg_q),
    .zero_q(zero_q), .eovf_q(eovf_q), .x_q(x_q), .p_q(p_q), .s_q(s_q)
  );

  divs_fix #(.DW(DW)) u_fix (
    .done(done), .form(form_q), .a_neg(a_neg_q), .q_neg(q_neg_q),
    .zero(zero_q), .eovf(eovf_q), .x(x_q), .p(p_q), .s(s_q),
    .result_q(result_q), .result_r(result_r), .wr_q(wr_q), .wr_r(wr_r),
    .flag_x(flag_x), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
    .flag_c(flag_c), .trap_zero(trap_zero)
  );

  assert_no_write_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_s_q)
    trap_zero |-> (!wr_q && !wr_r && !flag_v && !flag_n && !flag_z));
  assert_no_write_on_ovf_R6: assert property (@(posedge clk) disable iff (!rst_s_q)
    flag_v |-> (!wr_q && !wr_r && !flag_n && !flag_z));
  assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rst_s_q)
    flag_z |-> !flag_n);
  assert_rem_needs_quot_R3: assert property (@(posedge clk) disable iff (!rst_s_q)
    wr_r |-> wr_q);
  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_s_q)
    !done |-> (!wr_q && !wr_r && !trap_zero && !flag_v && !flag_n && !flag_z));

endmodule

// File: tb/tb_divs_unit.sv
`timescale 1ns/1ps
module tb_divs_unit;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    form = 2'd0;
  logic [DW-1:0] dvd_hi = '0, dvd_lo = '0, dvs = '0;
  logic          x_in = 1'b0;
  logic          busy, done, wr_q, wr_r, flag_x, flag_n, flag_z, flag_v, flag_c, trap_zero;
  logic [DW-1:0] result_q, result_r;

  int nchecks = 0;
  int nfails  = 0;
  bit ended   = 0;

  always #2.5 clk = ~clk;

  divs_unit #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .form(form), .dvd_hi(dvd_hi),
    .dvd_lo(dvd_lo), .dvs(dvs), .x_in(x_in), .busy(busy), .done(done),
    .result_q(result_q), .result_r(result_r), .wr_q(wr_q), .wr_r(wr_r),
    .flag_x(flag_x), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
    .flag_c(flag_c), .trap_zero(trap_zero)
  );

  localparam logic [7:0] DVL [12] = '{8'h00, 8'h01, 8'hff, 8'h02, 8'hfe, 8'h03,
                                      8'h07, 8'hf9, 8'h7f, 8'h80, 8'h05, 8'hfd};
  localparam logic [7:0] HIL [8]  = '{8'h00, 8'h01, 8'hff, 8'h7f, 8'h80, 8'h03, 8'hfc, 8'h40};

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nchecks++;
    if (act != exp) begin
      nfails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
      $finish;
    end
  endtask

  // wait for done, counting negedges since the start edge
  task automatic wait_done(output int n);
    n = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_op(input logic [1:0] f, input logic [7:0] hi, input logic [7:0] lo,
                        input logic [7:0] dv, input logic xi);
    longint a, b, q, r, am, bm, lim;
    int     qw, lat, n;
    bit     zero, ovf, early, ewq, ewr;
    string  tg;
    logic [7:0] eq, er;
    case (f)
      2'd0: begin a = longint'($signed(lo)); b = longint'($signed(dv[3:0])); qw = 4; end
      2'd3: begin a = longint'($signed({hi, lo})); b = longint'($signed(dv)); qw = 8; end
      default: begin a = longint'($signed(lo)); b = longint'($signed(dv)); qw = 8; end
    endcase
    tg   = (f == 2'd0) ? "R1" : (f == 2'd1) ? "R2" : (f == 2'd2) ? "R3" : "R4";
    zero = (b == 0);
    q = 0; r = 0; ovf = 0;
    if (!zero) begin
      q = a / b;
      r = a % b;
      lim = longint'(1) << (qw - 1);
      ovf = (q >= lim) || (q < -lim);
    end
    am = (a < 0) ? -a : a;
    bm = (b < 0) ? -b : b;
    early = zero || ((am >> qw) >= bm);
    lat = early ? 1 : qw + 1;
    if (zero) tg = "R5"; else if (ovf) tg = "R6";
    ewq = !zero && !ovf;
    ewr = ewq && (f == 2'd2 || f == 2'd3);
    eq  = (f == 2'd0) ? {r[3:0], q[3:0]} : q[7:0];
    er  = r[7:0];

    @(negedge clk);
    start = 1'b1; form = f; dvd_hi = hi; dvd_lo = lo; dvs = dv; x_in = xi;
    wait_done(n);
    chk("R8", "latency", n, lat);
    chk(tg, "trap_zero", trap_zero, zero);
    chk(tg, "wr_q", wr_q, ewq);
    chk(tg, "wr_r", wr_r, ewr);
    chk(tg, "flag_v", flag_v, !zero && ovf);
    chk("R7", "flag_n", flag_n, ewq && (q < 0));
    chk("R7", "flag_z", flag_z, ewq && (q == 0));
    chk("R7", "flag_c", flag_c, 0);
    chk("R7", "flag_x", flag_x, xi);
    if (ewq) chk(tg, "result_q", result_q, eq);
    if (ewr) chk(tg, "result_r", result_r, er);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // reset state (R9)
    chk("R9", "reset busy", busy, 0);
    chk("R9", "reset done", done, 0);
    chk("R9", "reset wr_q", wr_q, 0);
    chk("R9", "reset trap", trap_zero, 0);

    // R1 half-width form: exhaustive, upper divisor bits and dvd_hi scrambled
    for (int d = 0; d < 16; d++)
      for (int v = 0; v < 256; v++)
        run_op(2'd0, 8'(v) ^ 8'h3c, 8'(v), {4'(d) ^ 4'ha, 4'(d)}, v[0]);

    // R2 long quotient-only
    for (int k = 0; k < 12; k++)
      for (int v = 0; v < 256; v++)
        run_op(2'd1, 8'(v) ^ 8'h5a, 8'(v), DVL[k], v[1]);

    // R3 long with remainder
    for (int k = 0; k < 12; k++)
      for (int v = 0; v < 256; v += 2)
        run_op(2'd2, 8'h00, 8'(v), DVL[k], v[1]);

    // R4 double form grid
    for (int h = 0; h < 8; h++)
      for (int k = 0; k < 12; k++)
        for (int v = 0; v < 256; v += 15)
          run_op(2'd3, HIL[h], 8'(v), DVL[k], v[0]);

    // R6 bounds in the double form
    run_op(2'd3, 8'hff, 8'h80, 8'h01, 1'b0);  // -128 / 1 fits
    run_op(2'd3, 8'hff, 8'h80, 8'hff, 1'b1);  // -128 / -1 overflows
    run_op(2'd3, 8'h80, 8'h00, 8'hff, 1'b0);  // most negative / -1
    run_op(2'd3, 8'h3f, 8'hc0, 8'h7f, 1'b1);  // 16320/127 = 128 overflows
    run_op(2'd1, 8'h00, 8'h80, 8'hff, 1'b0);  // -128 / -1 long form

    // R9: start while busy ignored, done one cycle, outputs quiet afterwards
    @(negedge clk);
    start = 1'b1; form = 2'd2; dvd_hi = 8'h00; dvd_lo = 8'h64; dvs = 8'h07; x_in = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R9", "busy mid-run", busy, 1);
    start = 1'b1; form = 2'd0; dvd_lo = 8'h9c; dvs = 8'h00; x_in = 1'b0;
    @(negedge clk);
    start = 1'b0;
    n = 3;
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk("R9", "latency with busy start", n, 9);
    chk("R9", "quotient kept", result_q, 14);
    chk("R9", "remainder kept", result_r, 2);
    chk("R9", "x kept", flag_x, 1);
    chk("R9", "trap not raised", trap_zero, 0);
    @(negedge clk);
    chk("R9", "done one cycle", done, 0);
    chk("R9", "wr_q quiet", wr_q, 0);
    chk("R9", "wr_r quiet", wr_r, 0);
    chk("R9", "busy cleared", busy, 0);

    finish_run();
  end

endmodule